// File: doc/BRIEF.md
# SPI master burst transfer engine

This block turns a queue of 32-bit words into byte transfers on an SPI bus where it is the master, and gathers the bytes that come back into 32-bit receive words. Software sets the burst length in bits through a control field. The engine rounds the length up to whole bytes and cuts the burst into words. The first word of a burst carries only the part of the burst that does not fill a whole 32-bit word. Every later word carries a full 32 bits. Within a word the bytes leave most significant first. Each returned byte shifts into the low end of the receive word.

A transfer can start in one of two ways. In immediate mode, data that lands in the transmit queue is sent as soon as the selected channel is a master. In exchange mode, data waits until an exchange request arrives. In exchange mode a per-channel chaining bit lets several bursts run back to back under one request. The engine gives a one-cycle completion pulse and a one-cycle overflow pulse, and it shows the exchange state. Both queues are built inside the engine. Dropping the enable flushes both queues and clears all progress.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is `cfg_burst_len + 1`, rounded up to the next multiple of 8.
- R2: The first word of a burst sends (remaining bits mod 32) bits, or 32 bits when that remainder is 0. The following words of the burst send 32 bits each. The bits sent are the low bits of the word, most significant byte first (byte k-1 down to byte 0 for a k-byte word).
- R3: Each byte is offered on `spi_tx_valid`/`spi_tx_byte` and held until `spi_tx_ready`. The engine then waits for `spi_rx_done`. Each returned byte shifts into bit 7:0 of the receive word, so a short word has zero upper bytes.
- R4: In immediate mode (`cfg_auto_start`=1) the engine starts draining whenever it is idle, enabled, the selected channel is a master and the transmit queue is non-empty. Each burst that ends gives one `done_pulse`.
- R5: If the receive queue is full when a word completes, that word is dropped and `ovf_pulse` is high for one cycle.
- R6: In exchange mode (`cfg_auto_start`=0), nothing is sent until an `xch_req` pulse. The pulse sets `xch_busy` and starts draining. If the transmit queue is empty at that point, `done_pulse` fires and `xch_busy` clears without any byte being sent.
- R7: When the selected channel is a master, `cfg_auto_start`=0 and the channel's bit in `cfg_chain_mask` is 1, bursts follow one another until the transmit queue is empty, with a single `done_pulse`. Without chaining, draining stops after one burst with `done_pulse`, and `xch_busy` stays set while data remains.
- R8: When the transmit queue is empty at the end of a word, `done_pulse` fires and `xch_busy` clears.
- R9: While the selected channel (`cfg_master_mask[cfg_chan_sel]`=0) is not a master, no byte is sent and queued words stay queued.
- R10: While `cfg_enable`=0, both queues are flushed and burst progress and `xch_busy` are cleared. `tx_wr_ready` and `rx_rd_valid` are held at 0.
- R11: Burst progress survives a stop caused by an empty queue. A later word continues the same burst rather than starting a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Block enable; 0 flushes and clears |
| cfg_burst_len | input | BLEN_W | Burst length in bits minus one |
| cfg_auto_start | input | 1 | 1: immediate mode, 0: exchange mode |
| cfg_chan_sel | input | CH_W | Selected channel |
| cfg_master_mask | input | NUM_CH | Per-channel master flag |
| cfg_chain_mask | input | NUM_CH | Per-channel burst chaining flag |
| xch_req | input | 1 | One-cycle exchange request |
| tx_wr_valid | input | 1 | Transmit word write strobe |
| tx_wr_data | input | 32 | Transmit word |
| tx_wr_ready | output | 1 | Transmit queue accepts a word |
| rx_rd_en | input | 1 | Receive word read strobe |
| rx_rd_data | output | 32 | Head of receive queue |
| rx_rd_valid | output | 1 | Receive queue holds a word |
| spi_tx_valid | output | 1 | Byte offered to the SPI shifter |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_tx_ready | input | 1 | Shifter takes the byte |
| spi_rx_done | input | 1 | Shifter finished, returned byte valid |
| spi_rx_byte | input | 8 | Returned byte |
| xch_busy | output | 1 | Exchange bit state |
| done_pulse | output | 1 | Transfer complete, one cycle |
| ovf_pulse | output | 1 | Receive word dropped, one cycle |

## Verification
The bench builds the engine with 4-word queues, two channels and an 8-bit length field. With queues that shallow, five words fill the receive side and force an overflow. With two channels, one channel can be left non-master to show that queued data is held back. The 8-bit field still reaches the 16-, 32-, 40- and 64-bit bursts. These bursts exercise the rounding, the short first word, bursts that span several words, and chaining.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
// Shared constants and the sequencer state type for the SPI burst engine.
package spi_burst_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_LOAD,   // fetching a word from the transmit queue
        ST_SEND,   // offering a byte to the shifter
        ST_WAIT,   // waiting for the returned byte
        ST_END     // word complete, storing the receive word
    } eng_state_t;
endpackage

// File: rtl/sbe_fifo.sv
`timescale 1ns/1ps
// Synchronous show-ahead FIFO.
// Assumes: the caller never pushes when full or pops when empty (checked);
// flush empties the queue in one cycle and has priority over push/pop.
module sbe_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // R2: words are only fetched when one is present
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n || flush)
        pop |-> !empty);
    // R5: receive words are never pushed into a full queue
    p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n || flush)
        push |-> !full);
endmodule

// File: rtl/sbe_sequencer.sv
`timescale 1ns/1ps
// Burst sequencer: fetches transmit words, splits them into bytes for the
// shifter handshake, rebuilds receive words and raises status pulses.
// Assumes: BLEN_W >= 4; spi_rx_done arrives after the byte was accepted;
// a low enable acts as a soft clear of all progress.
module sbe_sequencer
    import spi_burst_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BLEN_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BLEN_W-1:0] burst_len,
    input  logic              auto_start,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [NUM_CH-1:0] master_mask,
    input  logic [NUM_CH-1:0] chain_mask,
    input  logic              xch_req,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              spi_tx_valid,
    output logic [BYTE_W-1:0] spi_tx_byte,
    input  logic              spi_tx_ready,
    input  logic              spi_rx_done,
    input  logic [BYTE_W-1:0] spi_rx_byte,
    output logic              xch_busy,
    output logic              done_pulse,
    output logic              ovf_pulse
);
    localparam int REM_W = BLEN_W + 1;

    eng_state_t        st_q;
    logic [REM_W-1:0]  burst_rem;
    logic [2:0]        bytes_left;
    logic [WORD_W-1:0] word_q, acc_q;
    logic              kick_q, xch_q, done_q, ovf_q;

    logic [REM_W-1:0]  len_bits, full_bits, rem_eff;
    logic [2:0]        word_bytes;
    logic              sel_master, chained, req_ok, go;

    // Channel qualification and start conditions.
    assign sel_master = master_mask[chan_sel];
    assign chained    = sel_master && !auto_start && chain_mask[chan_sel];
    assign req_ok     = xch_req && !auto_start && sel_master;
    assign go         = sel_master && ((auto_start && !tx_empty) || kick_q);

    // Burst length rounded up to whole bytes, and the byte count of the next word.
    assign len_bits   = REM_W'(burst_len) + REM_W'(1);
    assign full_bits  = (len_bits + REM_W'(7)) & ~REM_W'(7);
    assign rem_eff    = (burst_rem == '0) ? full_bits : burst_rem;
    assign word_bytes = (rem_eff[4:3] == 2'b00) ? 3'd4 : {1'b0, rem_eff[4:3]};

    // Byte selection, most significant remaining byte first.
    always_comb begin
        case (bytes_left)
            3'd4:    spi_tx_byte = word_q[31:24];
            3'd3:    spi_tx_byte = word_q[23:16];
            3'd2:    spi_tx_byte = word_q[15:8];
            default: spi_tx_byte = word_q[7:0];
        endcase
    end

    assign spi_tx_valid = (st_q == ST_SEND);
    assign tx_pop       = (st_q == ST_LOAD);
    assign rx_push      = (st_q == ST_END) && !rx_full;
    assign rx_data      = acc_q;
    assign xch_busy     = xch_q;
    assign done_pulse   = done_q;
    assign ovf_pulse    = ovf_q;

    // Main sequencing state machine with status bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st_q       <= ST_IDLE;
            burst_rem  <= '0;
            bytes_left <= '0;
            word_q     <= '0;
            acc_q      <= '0;
            kick_q     <= 1'b0;
            xch_q      <= 1'b0;
            done_q     <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        kick_q <= 1'b0;
                        if (tx_empty) begin
                            done_q <= 1'b1;
                            xch_q  <= 1'b0;
                        end else begin
                            st_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    word_q     <= tx_data;
                    burst_rem  <= rem_eff;
                    bytes_left <= word_bytes;
                    acc_q      <= '0;
                    if (burst_rem == '0 && chained) xch_q <= 1'b1;
                    st_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (spi_tx_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (spi_rx_done) begin
                        acc_q      <= {acc_q[WORD_W-BYTE_W-1:0], spi_rx_byte};
                        burst_rem  <= burst_rem - REM_W'(8);
                        bytes_left <= bytes_left - 3'd1;
                        st_q       <= (bytes_left == 3'd1) ? ST_END : ST_SEND;
                    end
                end
                ST_END: begin
                    if (rx_full) ovf_q <= 1'b1;
                    if (burst_rem == '0 && !chained) begin
                        done_q <= 1'b1;
                        if (tx_empty) xch_q <= 1'b0;
                        st_q <= ST_IDLE;
                    end else if (tx_empty) begin
                        done_q <= 1'b1;
                        xch_q  <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q <= ST_LOAD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
            if (req_ok) begin
                kick_q <= 1'b1;
                xch_q  <= 1'b1;
            end
        end
    end

    // R3: an offered byte stays put until the shifter takes it
    p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        spi_tx_valid && !spi_tx_ready |=> spi_tx_valid && $stable(spi_tx_byte));
    // R5: an overflow pulse only follows a word that met a full receive queue
    p_ovf_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(rx_full));
    // R8: the exchange bit only drops on an empty queue or a disable
    p_xch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xch_busy) |-> ($past(tx_empty) || !$past(enable)));
    // R4: completion is reported together with the return to idle
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> st_q == ST_IDLE);
endmodule

// File: rtl/spi_burst_engine.sv
`timescale 1ns/1ps
// SPI master burst engine top: transmit and receive word queues around the
// burst sequencer. Assumes the SPI shifter behind the byte handshake
// handles clocking and chip select timing.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int NUM_CH     = 4,
    parameter int BLEN_W     = 12,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [BLEN_W-1:0] cfg_burst_len,
    input  logic              cfg_auto_start,
    input  logic [CH_W-1:0]   cfg_chan_sel,
    input  logic [NUM_CH-1:0] cfg_master_mask,
    input  logic [NUM_CH-1:0] cfg_chain_mask,
    input  logic              xch_req,
    input  logic              tx_wr_valid,
    input  logic [31:0]       tx_wr_data,
    output logic              tx_wr_ready,
    input  logic              rx_rd_en,
    output logic [31:0]       rx_rd_data,
    output logic              rx_rd_valid,
    output logic              spi_tx_valid,
    output logic [7:0]        spi_tx_byte,
    input  logic              spi_tx_ready,
    input  logic              spi_rx_done,
    input  logic [7:0]        spi_rx_byte,
    output logic              xch_busy,
    output logic              done_pulse,
    output logic              ovf_pulse
);
    logic              tx_empty, tx_full, tx_pop;
    logic [WORD_W-1:0] tx_head;
    logic              rx_empty, rx_full, rx_push;
    logic [WORD_W-1:0] rx_word;

    // Edge gating: nothing enters or leaves the queues while disabled.
    assign tx_wr_ready = cfg_enable && !tx_full;
    assign rx_rd_valid = cfg_enable && !rx_empty;

    sbe_fifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!cfg_enable),
        .push  (tx_wr_valid && tx_wr_ready),
        .din   (tx_wr_data),
        .pop   (tx_pop),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    sbe_fifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!cfg_enable),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rx_rd_en && rx_rd_valid),
        .dout  (rx_rd_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    sbe_sequencer #(.NUM_CH(NUM_CH), .BLEN_W(BLEN_W), .CH_W(CH_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .burst_len    (cfg_burst_len),
        .auto_start   (cfg_auto_start),
        .chan_sel     (cfg_chan_sel),
        .master_mask  (cfg_master_mask),
        .chain_mask   (cfg_chain_mask),
        .xch_req      (xch_req),
        .tx_empty     (tx_empty),
        .tx_data      (tx_head),
        .tx_pop       (tx_pop),
        .rx_full      (rx_full),
        .rx_push      (rx_push),
        .rx_data      (rx_word),
        .spi_tx_valid (spi_tx_valid),
        .spi_tx_byte  (spi_tx_byte),
        .spi_tx_ready (spi_tx_ready),
        .spi_rx_done  (spi_rx_done),
        .spi_rx_byte  (spi_rx_byte),
        .xch_busy     (xch_busy),
        .done_pulse   (done_pulse),
        .ovf_pulse    (ovf_pulse)
    );
endmodule

// File: tb/test_spi_burst_engine.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected bytes and receive words, the
// shifter model and the read task compare them as the engine produces them.
module test_spi_burst_engine;
    localparam int DEPTH = 4;
    localparam int NCH   = 2;
    localparam int BLW   = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n, cfg_enable, cfg_auto_start, xch_req;
    logic [BLW-1:0] cfg_burst_len;
    logic [0:0]     cfg_chan_sel;
    logic [NCH-1:0] cfg_master_mask, cfg_chain_mask;
    logic           tx_wr_valid, tx_wr_ready, rx_rd_en, rx_rd_valid;
    logic [31:0]    tx_wr_data, rx_rd_data;
    logic           spi_tx_valid, spi_tx_ready, spi_rx_done;
    logic [7:0]     spi_tx_byte, spi_rx_byte;
    logic           xch_busy, done_pulse, ovf_pulse;

    spi_burst_engine #(.FIFO_DEPTH(DEPTH), .NUM_CH(NCH), .BLEN_W(BLW)) i_spi_burst_engine (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_burst_len(cfg_burst_len),
        .cfg_auto_start(cfg_auto_start), .cfg_chan_sel(cfg_chan_sel),
        .cfg_master_mask(cfg_master_mask), .cfg_chain_mask(cfg_chain_mask),
        .xch_req(xch_req), .tx_wr_valid(tx_wr_valid), .tx_wr_data(tx_wr_data),
        .tx_wr_ready(tx_wr_ready), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .rx_rd_valid(rx_rd_valid), .spi_tx_valid(spi_tx_valid), .spi_tx_byte(spi_tx_byte),
        .spi_tx_ready(spi_tx_ready), .spi_rx_done(spi_rx_done), .spi_rx_byte(spi_rx_byte),
        .xch_busy(xch_busy), .done_pulse(done_pulse), .ovf_pulse(ovf_pulse)
    );

    int          n_chk = 0, n_bad = 0;
    int          n_bytes = 0, n_done = 0, n_ovf = 0;
    logic [7:0]  exp_b[$];
    logic [31:0] exp_w[$];
    string       cur_req = "R2";
    bit          finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Status pulse counters.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_pulse) n_done++;
            if (ovf_pulse)  n_ovf++;
        end
    end

    // Shifter model: takes a byte at once, answers two cycles later with byte ^ A5.
    initial begin : shifter
        logic [7:0] b;
        spi_tx_ready = 1'b1;
        spi_rx_done  = 1'b0;
        spi_rx_byte  = '0;
        @(negedge clk);
        forever begin
            if (spi_tx_valid === 1'b1) begin
                b = spi_tx_byte;
                n_bytes++;
                if (exp_b.size() == 0) chk({cur_req, " unexpected byte"}, 32'(b), 32'hFFFF_FFFF);
                else chk({cur_req, " byte order"}, 32'(b), 32'(exp_b.pop_front()));
                @(negedge clk);
                @(negedge clk);
                spi_rx_byte = b ^ 8'hA5;
                spi_rx_done = 1'b1;
                @(negedge clk);
                spi_rx_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Expected bytes of one word (nb low bytes, top first) and its receive word.
    task automatic plan_word(logic [31:0] w, int nb, bit keep);
        logic [31:0] acc = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            exp_b.push_back(w[8*i +: 8]);
            acc = {acc[23:0], w[8*i +: 8] ^ 8'hA5};
        end
        if (keep) exp_w.push_back(acc);
    endtask

    task automatic put_word(logic [31:0] w);
        @(negedge clk);
        while (!tx_wr_ready) @(negedge clk);
        tx_wr_valid = 1'b1;
        tx_wr_data  = w;
        @(negedge clk);
        tx_wr_valid = 1'b0;
    endtask

    task automatic pulse_xch();
        @(negedge clk);
        xch_req = 1'b1;
        @(negedge clk);
        xch_req = 1'b0;
    endtask

    task automatic settle();
        while (exp_b.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic drain_rx(int n, string tag);
        repeat (n) begin
            @(negedge clk);
            chk({tag, " rx valid"}, 32'(rx_rd_valid), 32'd1);
            if (exp_w.size() != 0) chk({tag, " rx word"}, rx_rd_data, exp_w.pop_front());
            rx_rd_en = 1'b1;
            @(negedge clk);
            rx_rd_en = 1'b0;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int d_done, d_bytes, d_ovf;
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_auto_start = 1'b1; xch_req = 1'b0;
        cfg_burst_len = 8'd31; cfg_chan_sel = 1'b0; cfg_master_mask = 2'b01;
        cfg_chain_mask = 2'b00; tx_wr_valid = 1'b0; tx_wr_data = '0; rx_rd_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10 gating while disabled)
        chk("R10 reset tx_wr_ready", 32'(tx_wr_ready), 32'd0);
        chk("R10 reset rx_rd_valid", 32'(rx_rd_valid), 32'd0);
        chk("R3 reset spi_tx_valid", 32'(spi_tx_valid), 32'd0);
        chk("R6 reset xch_busy", 32'(xch_busy), 32'd0);
        cfg_enable = 1'b1;
        @(negedge clk);
        chk("R10 enabled tx_wr_ready", 32'(tx_wr_ready), 32'd1);

        // R1/R2/R4: 32-bit bursts in immediate mode
        cur_req = "R4"; d_done = n_done;
        plan_word(32'hA1B2C3D4, 4, 1);
        plan_word(32'h0F1E2D3C, 4, 1);
        put_word(32'hA1B2C3D4);
        put_word(32'h0F1E2D3C);
        settle();
        chk("R4 done per burst", 32'(n_done - d_done), 32'd2);
        drain_rx(2, "R3");

        // R1: 12-bit request rounds to 16 bits, 2 bytes per word
        cur_req = "R1"; cfg_burst_len = 8'd11; d_done = n_done;
        plan_word(32'h12345678, 2, 1);
        put_word(32'h12345678);
        settle();
        chk("R1 done", 32'(n_done - d_done), 32'd1);
        drain_rx(1, "R1");

        // R2: 40-bit burst, first word 1 byte then 4 bytes
        cur_req = "R2"; cfg_burst_len = 8'd39; d_done = n_done;
        plan_word(32'hAABBCCDD, 1, 1);
        plan_word(32'h11223344, 4, 1);
        put_word(32'hAABBCCDD);
        put_word(32'h11223344);
        settle();
        chk("R2 one burst", 32'(n_done - d_done), 32'd1);
        drain_rx(2, "R2");

        // R11: burst continues after an empty-queue stop
        cur_req = "R11"; d_done = n_done;
        plan_word(32'h55667788, 1, 1);
        put_word(32'h55667788);
        settle();
        chk("R11 stop on empty", 32'(n_done - d_done), 32'd1);
        plan_word(32'h99AABBCC, 4, 1);
        put_word(32'h99AABBCC);
        settle();
        chk("R11 continued", 32'(n_done - d_done), 32'd2);
        drain_rx(2, "R11");

        // R9: non-master channel holds data back
        cur_req = "R9"; cfg_burst_len = 8'd31; cfg_chan_sel = 1'b1; d_bytes = n_bytes;
        put_word(32'hCAFEF00D);
        repeat (20) @(negedge clk);
        chk("R9 no bytes", 32'(n_bytes - d_bytes), 32'd0);
        d_done = n_done;
        plan_word(32'hCAFEF00D, 4, 1);
        cfg_chan_sel = 1'b0;
        settle();
        chk("R9 released", 32'(n_done - d_done), 32'd1);
        drain_rx(1, "R9");

        // R6/R7: exchange mode without chaining, one burst per request
        cur_req = "R6"; cfg_auto_start = 1'b0; d_bytes = n_bytes; d_done = n_done;
        put_word(32'h01020304);
        put_word(32'h05060708);
        put_word(32'h090A0B0C);
        repeat (20) @(negedge clk);
        chk("R6 waits for request", 32'(n_bytes - d_bytes), 32'd0);
        plan_word(32'h01020304, 4, 1);
        pulse_xch();
        settle();
        cur_req = "R7";
        chk("R7 single burst done", 32'(n_done - d_done), 32'd1);
        chk("R7 stopped after burst", 32'(n_bytes - d_bytes), 32'd4);
        chk("R7 xch stays set", 32'(xch_busy), 32'd1);
        plan_word(32'h05060708, 4, 1);
        pulse_xch();
        settle();
        plan_word(32'h090A0B0C, 4, 1);
        pulse_xch();
        settle();
        chk("R8 xch cleared on empty", 32'(xch_busy), 32'd0);
        drain_rx(3, "R6");

        // R7: chained 64-bit bursts under one request
        cur_req = "R7"; cfg_chain_mask = 2'b01; cfg_burst_len = 8'd63; d_done = n_done;
        put_word(32'hDEADBEEF);
        put_word(32'h13579BDF);
        put_word(32'h2468ACE0);
        plan_word(32'hDEADBEEF, 4, 1);
        plan_word(32'h13579BDF, 4, 1);
        plan_word(32'h2468ACE0, 4, 1);
        pulse_xch();
        settle();
        chk("R7 chain one done", 32'(n_done - d_done), 32'd1);
        chk("R8 chain xch cleared", 32'(xch_busy), 32'd0);
        drain_rx(3, "R7");

        // R6: request with nothing queued
        cur_req = "R6"; d_done = n_done; d_bytes = n_bytes;
        pulse_xch();
        repeat (10) @(negedge clk);
        chk("R6 empty done", 32'(n_done - d_done), 32'd1);
        chk("R6 empty no bytes", 32'(n_bytes - d_bytes), 32'd0);
        chk("R6 empty xch clear", 32'(xch_busy), 32'd0);

        // R10: disable flushes both queues
        cur_req = "R10"; cfg_chain_mask = 2'b00; cfg_burst_len = 8'd31; cfg_auto_start = 1'b1;
        plan_word(32'h77777777, 4, 0);
        put_word(32'h77777777);
        settle();
        chk("R10 rx holds word", 32'(rx_rd_valid), 32'd1);
        cfg_auto_start = 1'b0;
        put_word(32'h88888888);
        put_word(32'h99999999);
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk("R10 disabled tx_wr_ready", 32'(tx_wr_ready), 32'd0);
        chk("R10 disabled rx_rd_valid", 32'(rx_rd_valid), 32'd0);
        cfg_enable = 1'b1; cfg_auto_start = 1'b1; d_bytes = n_bytes;
        repeat (20) @(negedge clk);
        chk("R10 tx flushed", 32'(n_bytes - d_bytes), 32'd0);
        chk("R10 rx flushed", 32'(rx_rd_valid), 32'd0);

        // R5: receive overflow drops the fifth word
        cur_req = "R5"; d_ovf = n_ovf;
        for (int i = 0; i < 5; i++) plan_word(32'h4000_0000 + 32'(i * 32'h0101_0101), 4, i < 4);
        for (int i = 0; i < 5; i++) put_word(32'h4000_0000 + 32'(i * 32'h0101_0101));
        settle();
        chk("R5 overflow pulses", 32'(n_ovf - d_ovf), 32'd1);
        drain_rx(4, "R5");
        @(negedge clk);
        chk("R5 dropped word absent", 32'(rx_rd_valid), 32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule